// File: doc/BRIEF.md
# Sensor Frame Checksum Unit

This block produces and verifies the 8-bit checksum that closes every 32-bit sensor frame. The checksum is an 8-bit cyclic code with generator x^8+x^4+x^3+x^2+1 (0x1D, top term implied). It covers only the three leading bytes of the frame, most significant bit first, starting from an all-ones register. The byte carried on the wire is the bitwise inverse of the register contents.

The same unit serves both directions. For an outgoing command, the host pulses start, feeds the three payload bytes, and appends `crc_o` as the fourth byte. For an incoming response, the host also presents the received fourth byte on `rx_chk_i` in the cycle `done_o` is high. The unit then raises or clears `mismatch_o` one cycle later and holds that verdict until the next start.

The payload path is `DIN_W` bits wide. With `DIN_W = 8` it takes one byte per accepted cycle. With `DIN_W = 1` it consumes a bit stream straight from a shift register. The results are identical either way. Serial shifting, register decoding and retry decisions belong to neighbouring blocks.

Top module: `frame_crc8`

## Requirements
- R1: After reset, `crc_o` reads 0x00 (the inverse of the 0xFF preset), `done_o` is 0 and `mismatch_o` is 0.
- R2: A one-cycle `start_i` presets the register to 0xFF, so `crc_o` reads 0x00 in the following cycle. A start has priority over a payload word offered in the same cycle, which is then dropped.
- R3: `crc_o` equals the bitwise inverse of the CRC-8 (polynomial 0x1D, MSB first, preset 0xFF) over the three payload bytes. The first byte offered is the most significant. For payload 0x040000 the result is 0xF7.
- R4: Only the first 24 payload bits after a start are absorbed. Words offered with `din_valid_i` high after the frame is complete, or before any start, leave `crc_o` unchanged.
- R5: `done_o` is high for exactly one cycle, the cycle right after the last payload word is accepted. In that cycle `crc_o` already holds the final checksum.
- R6: In the cycle after `done_o`, `mismatch_o` is 1 exactly when `rx_chk_i` (sampled in the `done_o` cycle) differs from `crc_o`. It then holds that value, whatever `rx_chk_i` does, until the next start.
- R7: `start_i` clears `mismatch_o` in the following cycle.
- R8: Cycles with `din_valid_i` low neither advance the frame nor change `crc_o`, so gaps between payload words do not alter the result.
- R9: A start in the middle of a frame abandons it. The next three bytes form a fresh frame.
- R10: With `DIN_W = 1` (one bit per accepted cycle, MSB first), the same payload gives the same `crc_o` and verdict as with `DIN_W = 8`. `done_o` follows the 24th accepted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a frame and presets the register |
| din_valid_i | input | 1 | Payload word on `din_i` is offered this cycle |
| din_i | input | DIN_W | Payload word, MSB is the earliest frame bit |
| rx_chk_i | input | 8 | Received fourth byte, sampled in the `done_o` cycle |
| crc_o | output | 8 | Inverted checksum register, final when `done_o` is high |
| done_o | output | 1 | One-cycle strobe after the last payload word |
| mismatch_o | output | 1 | Checksum verdict, valid from the cycle after `done_o` until next start |

## Verification
A table of fixed payloads is run through both the byte-wide and the bit-serial instance. The table covers all zeros, all ones, a single high bit at either end, alternating patterns, and the 0x040000 frame whose checksum is known to be 0xF7. These patterns separate a wrong polynomial, a missing inversion, a wrong preset and reversed bit order, since each of those faults changes a different subset of the results.

Random 24-bit payloads then stress the unrolled update across many register states. Each payload is paired with both a correct and a corrupted fourth byte, so that both verdict values are seen.

Directed frames with idle gaps, surplus words after completion, and a restart in mid-frame tell apart a correct frame counter from one that miscounts or keeps absorbing data.

// File: rtl/frame_crc8_pkg.sv
// Shared constants and types for the frame checksum unit.
// Assumes an 8-bit checksum with the x^8 term implied in the polynomial.
package frame_crc8_pkg;

    localparam int CRC_W = 8;

    typedef logic [CRC_W-1:0] crc_t;

    // Generator x^8+x^4+x^3+x^2+1 without its top term.
    localparam crc_t CRC_POLY = 8'h1D;

    // Register contents at the start of every frame.
    localparam crc_t CRC_SEED = 8'hFF;

endpackage : frame_crc8_pkg

// File: rtl/crc8_lane_step.sv
// Combinational update of the checksum register by DIN_W data bits.
// The MSB of data_i is the earliest bit on the wire. One shift-and-reduce
// stage is built per bit, chained so the whole word is absorbed in one cycle.
// Assumes DIN_W >= 1; logic depth grows linearly with DIN_W.
module crc8_lane_step
    import frame_crc8_pkg::*;
#(
    parameter int DIN_W = 8
) (
    input  crc_t             crc_i,
    input  logic [DIN_W-1:0] data_i,
    output crc_t             crc_o
);

    // chain[k] is the register after the first k bits of the word
    crc_t chain [DIN_W+1];

    assign chain[0] = crc_i;

    generate
        for (genvar b = 0; b < DIN_W; b++) begin : g_bit
            logic feedback;
            // feedback combines the register MSB with the next data bit
            assign feedback    = chain[b][CRC_W-1] ^ data_i[DIN_W-1-b];
            // shift left and fold the polynomial in when feedback is set
            assign chain[b+1]  = {chain[b][CRC_W-2:0], 1'b0} ^ (feedback ? CRC_POLY : '0);
        end
    endgenerate

    assign crc_o = chain[DIN_W];

endmodule : crc8_lane_step

// File: rtl/crc8_frame_seq.sv
// Frame sequencer: counts accepted payload words after a start and raises a
// one-cycle done strobe once STEPS words have been taken. Words offered
// while no frame is open, or together with a start, are not taken.
// Assumes STEPS >= 1.
module crc8_frame_seq #(
    parameter int STEPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic valid_i,
    output logic take_o,
    output logic done_o
);

    localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    logic             open_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // a word is absorbed only inside an open frame and never beside a start
    assign take_o = open_q & valid_i & ~start_i;
    assign done_o = done_q;

    // frame open flag, word counter and done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                open_q <= 1'b1;
                cnt_q  <= '0;
            end else if (take_o) begin
                if (cnt_q == LAST) begin
                    open_q <= 1'b0;
                    cnt_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R5: the strobe lasts a single cycle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: the strobe is always caused by an accepted word in the cycle before
    a_r5_done_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(take_o));

    // R4: the counter never leaves its range while a frame is open
    a_r4_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (cnt_q <= LAST));

    // R4: no word is taken once the frame has closed until a new start
    a_r4_closed_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |-> !take_o);

endmodule : crc8_frame_seq

// File: rtl/crc8_verdict.sv
// Verdict register: compares the received check byte with the computed
// checksum in the done cycle, and holds the result until the next start.
// Assumes ref_i is valid in the cycle done_i is high.
module crc8_verdict
    import frame_crc8_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic done_i,
    input  crc_t calc_i,
    input  crc_t ref_i,
    output logic mismatch_o
);

    logic mismatch_q;

    assign mismatch_o = mismatch_q;

    // capture the comparison on done, clear on start, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch_q <= 1'b0;
        end else if (start_i) begin
            mismatch_q <= 1'b0;
        end else if (done_i) begin
            mismatch_q <= (ref_i != calc_i);
        end
    end

    // R7: a start clears the verdict
    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !mismatch_o);

    // R6: outside done and start the verdict is held
    a_r6_verdict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !start_i) |=> $stable(mismatch_o));

    // R6: the verdict follows the comparison made in the done cycle
    a_r6_verdict_value: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> (mismatch_o == $past(ref_i != calc_i)));

endmodule : crc8_verdict

// File: rtl/frame_crc8.sv
// Sensor frame checksum unit. Absorbs the PAYLOAD_BYTES leading bytes of a
// frame, DIN_W bits per accepted cycle, MSB first, and presents the inverted
// CRC-8 (poly 0x1D, preset 0xFF) on crc_o. In the done cycle the received
// check byte is compared and the verdict is held on mismatch_o.
// Assumes PAYLOAD_BYTES*8 is a multiple of DIN_W.
module frame_crc8
    import frame_crc8_pkg::*;
#(
    parameter int DIN_W         = 8,
    parameter int PAYLOAD_BYTES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             din_valid_i,
    input  logic [DIN_W-1:0] din_i,
    input  logic [7:0]       rx_chk_i,
    output logic [7:0]       crc_o,
    output logic             done_o,
    output logic             mismatch_o
);

    localparam int FRAME_BITS = PAYLOAD_BYTES * 8;
    localparam int STEPS      = FRAME_BITS / DIN_W;

    crc_t crc_q;
    crc_t crc_next;
    logic take;
    logic done;

    // frame sequencing and word acceptance
    crc8_frame_seq #(
        .STEPS (STEPS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .valid_i (din_valid_i),
        .take_o  (take),
        .done_o  (done)
    );

    // next register value for the offered word
    crc8_lane_step #(
        .DIN_W (DIN_W)
    ) u_step (
        .crc_i  (crc_q),
        .data_i (din_i),
        .crc_o  (crc_next)
    );

    // checksum register: preset on start, update on an accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (start_i) begin
            crc_q <= CRC_SEED;
        end else if (take) begin
            crc_q <= crc_next;
        end
    end

    assign crc_o  = ~crc_q;
    assign done_o = done;

    // received check byte against the wire form of the checksum
    crc8_verdict u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .done_i     (done),
        .calc_i     (crc_o),
        .ref_i      (rx_chk_i),
        .mismatch_o (mismatch_o)
    );

    // R2: a start leaves the inverted preset on the output
    a_r2_start_preset: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (crc_o == 8'h00));

    // R4, R8: without an accepted word or start the output does not move
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !start_i) |=> $stable(crc_o));

    // R5: no update in the cycle the final checksum is shown
    a_r5_final_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(crc_o));

endmodule : frame_crc8

// File: tb/sim_frame_crc8.sv
// Bench for frame_crc8: byte-wide instance u0 and bit-serial instance u1,
// compared against a bit-serial reference model.
module sim_frame_crc8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       valid = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] rx_chk = '0;
    logic [7:0] crc8w;
    logic       done8w;
    logic       mis8w;
    logic       start1 = 1'b0;
    logic       valid1 = 1'b0;
    logic       din1 = 1'b0;
    logic [7:0] rx_chk1 = '0;
    logic [7:0] crc1w;
    logic       done1w;
    logic       mis1w;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    frame_crc8 #(.DIN_W(8), .PAYLOAD_BYTES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .din_valid_i(valid),
        .din_i(din), .rx_chk_i(rx_chk), .crc_o(crc8w), .done_o(done8w),
        .mismatch_o(mis8w));

    frame_crc8 #(.DIN_W(1), .PAYLOAD_BYTES(3)) u1 (
        .clk(clk), .rst_n(rst_n), .start_i(start1), .din_valid_i(valid1),
        .din_i(din1), .rx_chk_i(rx_chk1), .crc_o(crc1w), .done_o(done1w),
        .mismatch_o(mis1w));

    // payload vectors and the xor applied to the correct check byte
    localparam int NVEC = 8;
    localparam logic [23:0] PAY  [NVEC] = '{24'h040000, 24'h000000, 24'hFFFFFF,
                                            24'h800000, 24'h000001, 24'hA5A5A5,
                                            24'h5A5A5A, 24'h123456};
    localparam logic [7:0]  FLIP [NVEC] = '{8'h00, 8'h01, 8'h00, 8'h80,
                                            8'h00, 8'hFF, 8'h00, 8'h10};

    // reference: bit-serial CRC-8, poly 0x1D, preset 0xFF, inverted result
    function automatic logic [7:0] ref_crc(input logic [23:0] p);
        logic [7:0] r = 8'hFF;
        for (int i = 23; i >= 0; i--) begin
            logic fb = r[7] ^ p[i];
            r = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h1D;
        end
        return ~r;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // byte-wide frame: start, three bytes, verdict, surplus word
    task automatic frame8(input logic [23:0] p, input logic [7:0] flip);
        logic [7:0] e = ref_crc(p);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(crc8w == 8'h00, "R2 preset after start", crc8w, 8'h00);
        chk(mis8w == 1'b0, "R7 start clears verdict", mis8w, 0);
        for (int i = 0; i < 3; i++) begin
            din = p[23-8*i -: 8]; valid = 1'b1; @(negedge clk);
        end
        valid = 1'b0;
        chk(done8w == 1'b1, "R5 done after third byte", done8w, 1);
        chk(crc8w == e, "R3 checksum", crc8w, e);
        rx_chk = e ^ flip; @(negedge clk);
        chk(done8w == 1'b0, "R5 done single cycle", done8w, 0);
        chk(mis8w == (flip != 0), "R6 verdict", mis8w, flip != 0);
        rx_chk = ~rx_chk; din = 8'h3C; valid = 1'b1; @(negedge clk); valid = 1'b0;
        chk(crc8w == e, "R4 surplus word ignored", crc8w, e);
        chk(mis8w == (flip != 0), "R6 verdict held", mis8w, flip != 0);
    endtask

    // bit-serial frame on u1
    task automatic frame1(input logic [23:0] p, input logic [7:0] flip);
        logic [7:0] e = ref_crc(p);
        start1 = 1'b1; @(negedge clk); start1 = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            din1 = p[i]; valid1 = 1'b1; @(negedge clk);
        end
        valid1 = 1'b0;
        chk(done1w == 1'b1 && crc1w == e, "R10 serial checksum", {done1w, crc1w}, {1'b1, e});
        rx_chk1 = e ^ flip; @(negedge clk);
        chk(mis1w == (flip != 0), "R10 serial verdict", mis1w, flip != 0);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(crc8w == 8'h00 && !done8w && !mis8w, "R1 reset state",
            {done8w, mis8w, crc8w}, 0);
        // R4 data before any start is ignored
        din = 8'hAA; valid = 1'b1; @(negedge clk); valid = 1'b0;
        chk(crc8w == 8'h00 && !done8w, "R4 no frame open", crc8w, 0);
        // R3 known vector in the reference model
        chk(ref_crc(24'h040000) == 8'hF7, "R3 known vector model", ref_crc(24'h040000), 8'hF7);

        for (int v = 0; v < NVEC; v++) begin
            frame8(PAY[v], FLIP[v]);
            frame1(PAY[v], FLIP[v]);
        end

        for (int n = 0; n < 40; n++) begin
            logic [23:0] p = 24'($urandom);
            frame8(p, (n % 2 == 0) ? 8'h00 : 8'(1 << (n % 8)));
            frame1(p, (n % 2 == 1) ? 8'h00 : 8'h04);
        end

        // R8 gaps between bytes
        begin
            logic [23:0] p = 24'hC0FFEE;
            start = 1'b1; @(negedge clk); start = 1'b0;
            for (int i = 0; i < 3; i++) begin
                din = p[23-8*i -: 8]; valid = 1'b1; @(negedge clk);
                valid = 1'b0; din = 8'h77; repeat (2) @(negedge clk);
                if (i < 2) chk(done8w == 1'b0, "R8 no early done", done8w, 0);
            end
            chk(crc8w == ref_crc(p), "R8 gaps do not alter checksum", crc8w, ref_crc(p));
        end

        // R9 restart in mid-frame, R2 start beats a word in the same cycle
        begin
            logic [23:0] p = 24'h18_0000;
            start = 1'b1; @(negedge clk); start = 1'b0;
            din = 8'h99; valid = 1'b1; @(negedge clk);
            din = 8'h55; valid = 1'b1; start = 1'b1; @(negedge clk); start = 1'b0;
            chk(crc8w == 8'h00, "R2 start drops same-cycle word", crc8w, 0);
            for (int i = 0; i < 3; i++) begin
                din = p[23-8*i -: 8]; valid = 1'b1; @(negedge clk);
            end
            valid = 1'b0;
            chk(done8w && crc8w == ref_crc(p), "R9 restart gives fresh frame",
                crc8w, ref_crc(p));
        end

        // R7 start clears a set verdict
        frame8(24'h0C0000, 8'h02);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(mis8w == 1'b0, "R7 verdict cleared by start", mis8w, 0);
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule : sim_frame_crc8